// File: doc/BRIEF.md
# Three-Pass Subranging Flash Sequencer

This block is the digital half of a subranging analog-to-digital converter. A bank of 15 comparators is reused three times per conversion. On each pass the sequencer waits for the references to settle, reads the comparator outputs as a thermometer code, and reduces that code to a 4-bit digit. The digits resolved so far go back out as a segment base, so the next pass compares only inside the chosen segment. After the third pass the 12-bit straight-binary code is copied into an output latch.

A host starts a conversion with a one-cycle pulse on `cnv_go` and watches `ready`, which stays low until the new code is latched. The latched code reaches the data bus only while both active-low selects, `cs_n` and `rd_n`, are low. While a conversion is running, the previous result can still be read.

Top module: `subrange_seq`

## Requirements
- R1: After reset, `ready` is 1, `data_en` is 0, `data_out` is 0, and a read returns 0.
- R2: The first pass compares against 16 coarse divisions of full scale and fixes result bits [11:8].
- R3: While a conversion runs, `pass_idx` steps 0, 1, 2. During pass p, `ref_base` holds the digits resolved in earlier passes at their final bit positions, and all lower bits are zero. While idle, `pass_idx` is 0.
- R4: The latched result equals the input level for any code from 0 to 4095. Pass 0 fills bits [11:8], pass 1 fills bits [7:4] and pass 2 fills bits [3:0].
- R5: Each digit is the number of asserted comparator outputs (0 to 15). A thermometer code with a bubble gives the same digit as a clean code with the same number of ones.
- R6: `data_en` is 1 and `data_out` carries the latched result only when `cs_n`=0 and `rd_n`=0. Otherwise `data_out` is 0.
- R7: `ready` falls on the clock edge that accepts `cnv_go` and rises after exactly PASSES×SETTLE_CLKS cycles, which is 12 with the defaults.
- R8: A `cnv_go` pulse that arrives while `ready` is 0 is ignored. It neither restarts nor lengthens the conversion, and it does not corrupt the result.
- R9: The previously latched result stays unchanged and readable until the new conversion completes.
- R10: Codes are straight binary. Input level 2047 gives 0x7FF and level 2048 gives 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_go | input | 1 | Conversion start pulse, accepted only while ready |
| cmp_therm | input | 15 | Comparator thermometer code for the current pass |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| ready | output | 1 | High when idle; low during conversion |
| pass_idx | output | 2 | Current pass number |
| ref_base | output | 12 | Segment base that sets the comparator references |
| data_out | output | 12 | Bus data, zero when not enabled |
| data_en | output | 1 | Bus drive enable |

## Verification
The assertions watch, on every cycle, the invariants of the sequence. The pass index stays in range and sits at zero while idle. The segment base never holds bits below the current pass. The output latch holds still during a conversion. The bus reads zero whenever it is not enabled, and `ready` falls only after a start pulse. The bench scenarios are needed to show the rest: that the digits actually reproduce the input level, including at midscale and at both ends of the range; that a bubbled thermometer code encodes the same as a clean one; that the conversion lasts exactly twelve cycles; and that a second start pulse is ignored.

// File: rtl/subr_pkg.sv
package subr_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } conv_st_e;
endpackage

// File: rtl/therm_count.sv
module therm_count #(
   parameter int N_IN  = 15,
   parameter int CNT_W = 4
) (
   input  logic [N_IN-1:0]  therm,
   output logic [CNT_W-1:0] count
);
   if ((1 << CNT_W) != N_IN + 1) begin : g_bad_width
      $error("therm_count: N_IN must equal 2**CNT_W - 1");
   end

   // Counting ones tolerates bubbles in the thermometer code
   always_comb begin
      count = '0;
      for (int i = 0; i < N_IN; i++) begin
         count = count + CNT_W'(therm[i]);
      end
   end
endmodule

// File: rtl/pass_ctrl.sv
module pass_ctrl
   import subr_pkg::*;
#(
   parameter int PASSES      = 3,
   parameter int SETTLE_CLKS = 4,
   parameter int PIDX_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv_go,
   output logic              ready,
   output logic [PIDX_W-1:0] pass_idx,
   output logic              sample_en,
   output logic              last_pass
);
   localparam int SCNT_W = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;

   if (SETTLE_CLKS < 1) begin : g_bad_settle
      $error("pass_ctrl: SETTLE_CLKS must be at least 1");
   end
   if (PASSES < 1 || (1 << PIDX_W) < PASSES) begin : g_bad_pass
      $error("pass_ctrl: PIDX_W too narrow for PASSES");
   end

   conv_st_e st_q;
   logic     settle_done;

   assign ready     = (st_q == ST_IDLE);
   assign last_pass = (pass_idx == PIDX_W'(PASSES - 1));
   assign sample_en = (st_q == ST_CONV) && settle_done;

   if (SETTLE_CLKS == 1) begin : g_no_settle
      assign settle_done = 1'b1;
   end else begin : g_settle
      logic [SCNT_W-1:0] scnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scnt_q <= '0;
         end else if (st_q == ST_IDLE || settle_done) begin
            scnt_q <= '0;
         end else begin
            scnt_q <= scnt_q + 1'b1;
         end
      end
      assign settle_done = (scnt_q == SCNT_W'(SETTLE_CLKS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         pass_idx <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (cnv_go) begin
                  st_q     <= ST_CONV;
                  pass_idx <= '0;
               end
            end
            default: begin
               if (sample_en) begin
                  if (last_pass) begin
                     st_q     <= ST_IDLE;
                     pass_idx <= '0;
                  end else begin
                     pass_idx <= pass_idx + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pass_idx) < PASSES); // R3
   AST_IDLE_PASS0: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> pass_idx == '0); // R3
   AST_START_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(cnv_go)); // R7
endmodule

// File: rtl/result_reg.sv
module result_reg #(
   parameter int PASS_BITS = 4,
   parameter int PASSES    = 3,
   parameter int RES_W     = 12,
   parameter int PIDX_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_acc,
   input  logic                 converting,
   input  logic                 sample_en,
   input  logic                 last_pass,
   input  logic [PIDX_W-1:0]    pass_idx,
   input  logic [PASS_BITS-1:0] digit,
   input  logic                 cs_n,
   input  logic                 rd_n,
   output logic [RES_W-1:0]     ref_base,
   output logic [RES_W-1:0]     data_out,
   output logic                 data_en
);
   if (RES_W != PASS_BITS * PASSES) begin : g_bad_res
      $error("result_reg: RES_W must equal PASS_BITS*PASSES");
   end

   logic [RES_W-1:0] acc_q, acc_nxt, res_q, low_mask;

   always_comb begin
      int ofs;
      ofs     = (PASSES - 1 - int'(pass_idx)) * PASS_BITS;
      acc_nxt = acc_q;
      acc_nxt[ofs +: PASS_BITS] = digit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         res_q <= '0;
      end else begin
         if (clear_acc) begin
            acc_q <= '0;
         end else if (sample_en) begin
            acc_q <= acc_nxt;
         end
         if (sample_en && last_pass) begin
            res_q <= acc_nxt;
         end
      end
   end

   assign ref_base = acc_q;
   assign data_en  = !cs_n && !rd_n;
   assign data_out = data_en ? res_q : '0;

   assign low_mask = {RES_W{1'b1}} >> (PASS_BITS * int'(pass_idx));

   AST_SEG_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      converting |-> (acc_q & low_mask) == '0); // R3
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (converting && $past(converting)) |-> $stable(res_q)); // R9
   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !data_en |-> data_out == '0); // R6
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq #(
   parameter int PASS_BITS   = 4,
   parameter int PASSES      = 3,
   parameter int SETTLE_CLKS = 4,
   localparam int NCMP   = (1 << PASS_BITS) - 1,
   localparam int RES_W  = PASS_BITS * PASSES,
   localparam int PIDX_W = (PASSES > 1) ? $clog2(PASSES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv_go,
   input  logic [NCMP-1:0]   cmp_therm,
   input  logic              cs_n,
   input  logic              rd_n,
   output logic              ready,
   output logic [PIDX_W-1:0] pass_idx,
   output logic [RES_W-1:0]  ref_base,
   output logic [RES_W-1:0]  data_out,
   output logic              data_en
);
   if (PASS_BITS < 1 || PASS_BITS > 8) begin : g_bad_bits
      $error("subrange_seq: PASS_BITS out of range");
   end

   logic                 sample_en, last_pass;
   logic [PASS_BITS-1:0] digit;

   pass_ctrl #(
      .PASSES(PASSES), .SETTLE_CLKS(SETTLE_CLKS), .PIDX_W(PIDX_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cnv_go(cnv_go), .ready(ready),
      .pass_idx(pass_idx), .sample_en(sample_en), .last_pass(last_pass)
   );

   therm_count #(.N_IN(NCMP), .CNT_W(PASS_BITS)) u_enc (
      .therm(cmp_therm), .count(digit)
   );

   result_reg #(
      .PASS_BITS(PASS_BITS), .PASSES(PASSES), .RES_W(RES_W), .PIDX_W(PIDX_W)
   ) u_res (
      .clk(clk), .rst_n(rst_n), .clear_acc(cnv_go && ready),
      .converting(!ready), .sample_en(sample_en), .last_pass(last_pass),
      .pass_idx(pass_idx), .digit(digit), .cs_n(cs_n), .rd_n(rd_n),
      .ref_base(ref_base), .data_out(data_out), .data_en(data_en)
   );
endmodule

// File: tb/sim_subrange_seq.sv
module sim_subrange_seq;
   localparam int CLK_PERIOD = 10;
   localparam int PB = 4, NP = 3, SC = 4;
   localparam int NC = (1 << PB) - 1;
   localparam int RW = PB * NP;
   localparam int CONV_CYC = NP * SC;
   localparam int NVEC = 8;
   // each entry: {input level, expected code}
   localparam logic [23:0] VEC [NVEC] = '{
      {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h7FF, 12'h7FF},
      {12'h800, 12'h800}, {12'hA5C, 12'hA5C}, {12'h123, 12'h123},
      {12'hF0F, 12'hF0F}, {12'h0F0, 12'h0F0}};

   logic clk = 0, rst_n = 0, cnv_go = 0, cs_n = 1, rd_n = 1;
   logic [NC-1:0] cmp_therm;
   logic ready, data_en;
   logic [1:0] pass_idx;
   logic [RW-1:0] ref_base, data_out;
   int vin = 0;
   bit bubble = 0;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   subrange_seq #(.PASS_BITS(PB), .PASSES(NP), .SETTLE_CLKS(SC)) u0 (
      .clk(clk), .rst_n(rst_n), .cnv_go(cnv_go), .cmp_therm(cmp_therm),
      .cs_n(cs_n), .rd_n(rd_n), .ready(ready), .pass_idx(pass_idx),
      .ref_base(ref_base), .data_out(data_out), .data_en(data_en));

   // comparator bank model
   always_comb begin
      int stp, n;
      logic [NC-1:0] t;
      stp = 1 << (PB * (NP - 1 - int'(pass_idx)));
      n = (vin >= int'(ref_base)) ? (vin - int'(ref_base)) / stp : 0;
      if (n > NC) n = NC;
      t = NC'((1 << n) - 1);
      if (bubble && n >= 1 && n <= NC - 1) t = t ^ NC'(3 << (n - 1));
      cmp_therm = t;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_read(output int val, output int en);
      @(negedge clk); cs_n = 0; rd_n = 0; #1;
      val = int'(data_out); en = int'(data_en);
      @(negedge clk); cs_n = 1; rd_n = 1;
   endtask

   // runs one conversion; returns cycles spent with ready low
   task automatic convert(input int level, input bit bub, input bit restart,
                          input int prev, output int low_cyc, output bit pfx_ok);
      int rv, re;
      vin = level; bubble = bub; pfx_ok = 1;
      @(negedge clk); cnv_go = 1;
      @(negedge clk); cnv_go = 0;
      low_cyc = 0;
      while (!ready && low_cyc < 100) begin
         if (pass_idx == 1 && ref_base != RW'(level & 12'hF00)) pfx_ok = 0;
         if (pass_idx == 2 && ref_base != RW'(level & 12'hFF0)) pfx_ok = 0;
         if (restart && low_cyc == 5) begin
            cnv_go = 1;
            @(negedge clk); cnv_go = 0; low_cyc++;
         end else if (restart && low_cyc == 7) begin
            cs_n = 0; rd_n = 0; #1;
            chk("R9 old result readable mid-conversion", int'(data_out), prev);
            @(negedge clk); cs_n = 1; rd_n = 1; low_cyc++;
         end else begin
            @(negedge clk); low_cyc++;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int rv, re, lc, last;
      bit ok;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ready after reset", int'(ready), 1);
      chk("R1 bus idle after reset", int'(data_en), 0);
      do_read(rv, re);
      chk("R1 read after reset", rv, 0);

      // R4 R2 R3 R7 R10 table walk
      for (int i = 0; i < NVEC; i++) begin
         convert(int'(VEC[i][23:12]), 0, 0, 0, lc, ok);
         chk("R7 conversion length", lc, CONV_CYC);
         chk("R3 segment base per pass", int'(ok), 1);
         do_read(rv, re);
         chk("R4 R10 result code", rv, int'(VEC[i][11:0]));
         chk("R2 top digit", rv >> 8, int'(VEC[i][11:8]));
         chk("R6 data_en during read", re, 1);
      end
      last = 12'h0F0;

      // R5 bubbled thermometer codes
      convert(12'h6B9, 1, 0, 0, lc, ok);
      do_read(rv, re);
      chk("R5 bubble resolved by ones count", rv, 12'h6B9);
      convert(12'hE27, 1, 0, 0, lc, ok);
      do_read(rv, re);
      chk("R5 bubble second level", rv, 12'hE27);
      last = 12'hE27;

      // R8 R9 start during conversion ignored, old result readable
      convert(12'h3C4, 0, 1, last, lc, ok);
      chk("R8 second start did not extend conversion", lc, CONV_CYC);
      do_read(rv, re);
      chk("R8 result after ignored start", rv, 12'h3C4);

      // R6 partial selects
      @(negedge clk); cs_n = 0; rd_n = 1; #1;
      chk("R6 cs only: data_en", int'(data_en), 0);
      chk("R6 cs only: data_out", int'(data_out), 0);
      @(negedge clk); cs_n = 1; rd_n = 0; #1;
      chk("R6 rd only: data_out", int'(data_out), 0);
      @(negedge clk); cs_n = 1; rd_n = 1;

      // R10 midscale pair, reset clears latch (R1)
      convert(2047, 0, 0, 0, lc, ok);
      do_read(rv, re);
      chk("R10 midscale low", rv, 12'h7FF);
      rst_n = 0; @(negedge clk); rst_n = 1;
      do_read(rv, re);
      chk("R1 latch cleared by reset", rv, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule